// File: doc/BRIEF.md
# Pipeline Hazard Controller for a Three-Stage Fetch/Execute/Commit Core

This block sequences a three-stage pipeline: fetch, then execute, then commit. It sits beside a register-to-register datapath that has 32-bit words. Every result leaves execute into a destination holding register and reaches the register file only in the following cycle, which is the commit stage. When an operand of the instruction now in execute names the register that the previous instruction is about to commit, the block raises a per-operand select. The datapath then takes that operand from the commit write data instead of the register file.

Memory instructions occupy execute for two cycles. In the first cycle the block stops fetch. In the second cycle the block reports a stall, and the result is captured only when memory reports completion, so a load or store costs one extra cycle. Other instructions move through at one per cycle.

The control is a two-state machine. In state RUN, instructions flow. In state SUSPEND, a memory access is finishing. There are four named transitions:
- FLOW: RUN to RUN, for a bubble or a non-memory instruction.
- MEM_ISSUE: RUN to SUSPEND, for a valid memory instruction.
- MEM_WAIT: SUSPEND to SUSPEND, while memory is not done.
- MEM_DONE: SUSPEND to RUN, once memory is done.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `rf_we`, `stall`, `fwd_rs1` and `fwd_rs2` are 0. The machine is in RUN, so `fetch_en` is 1 when no memory instruction is presented.
- R2: A valid non-memory instruction with `ex_wen`=1 and `ex_rd`≠0 drives `rf_we`=1, `rf_waddr`=`ex_rd` and `rf_wdata`=`ex_result` in the very next cycle, for one cycle only.
- R3: An instruction with `ex_rd`=0 or `ex_wen`=0 produces no register write in the next cycle, and no forward select.
- R4: `fwd_rs1` is 1 exactly when a valid instruction in execute has `ex_rs1` equal to the register being committed in that cycle.
- R5: The two operand comparisons are independent. `fwd_rs2` follows the same rule for `ex_rs2`, and both selects may be 1 together.
- R6: Only the immediately preceding instruction is forwarded. A source that matches an instruction two slots earlier gives a select of 0.
- R7: In RUN, a valid instruction with `ex_mem`=1 forces `fetch_en`=0 in that cycle. It also gives `stall`=1 and `rf_we`=0 in the next cycle.
- R8: In SUSPEND with `mem_done`=1, `fetch_en` is 1 and `stall` is 1 in that cycle. `stall` is 0 in the following cycle, so the suspension lasts exactly one cycle.
- R9: In SUSPEND with `mem_done`=0, `fetch_en` is 0 and the machine stays in SUSPEND (`stall`=1 in the next cycle).
- R10: A load is captured with the `ex_result` value presented in the cycle that `mem_done` is 1, and is committed in the next cycle. A dependent instruction in that cycle is forwarded.
- R11: A store (`ex_mem`=1, `ex_wen`=0) never produces a register write.
- R12: A cycle with `ex_valid`=0 is a bubble. It causes no write in the next cycle and no forward select, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rs1 | input | 5 | First source register number |
| ex_rs2 | input | 5 | Second source register number |
| ex_rd | input | 5 | Destination register number |
| ex_wen | input | 1 | Instruction writes a register |
| ex_mem | input | 1 | Instruction is a load or store |
| mem_done | input | 1 | Memory access completes this cycle |
| ex_result | input | 32 | Execute result, or load data while suspended |
| fetch_en | output | 1 | Fetch the next instruction this cycle |
| fwd_rs1 | output | 1 | Take operand 1 from `rf_wdata` |
| fwd_rs2 | output | 1 | Take operand 2 from `rf_wdata` |
| rf_we | output | 1 | Commit-stage register write enable |
| rf_waddr | output | 5 | Commit-stage register number |
| rf_wdata | output | 32 | Commit-stage data, also the forward value |
| stall | output | 1 | Execute repeats the memory instruction |

## Verification
The bench builds the block with its default parameters: 32-bit data, 5-bit register numbers and two operand ports. These values let it use register 31 and full-width data such as 0xFFFFFFFF in the commit path. The directed scenarios cover:
- back-to-back dependencies on one operand and on both operands;
- a chain where the matching instruction is two slots back;
- a load followed by a dependent instruction;
- a memory access whose completion is delayed;
- a store;
- bubbles.

For each of these, the stall length is counted in cycles.

// File: rtl/pipe_hazard_pkg.sv
`timescale 1ns/1ps
package pipe_hazard_pkg;
    localparam int unsigned XLEN_DEF   = 32;
    localparam int unsigned REG_AW_DEF = 5;
    localparam int unsigned NSRC_DEF   = 2;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_SUSPEND = 1'b1
    } phc_state_e;
endpackage

// File: rtl/phc_seq_fsm.sv
`timescale 1ns/1ps
module phc_seq_fsm
    import pipe_hazard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ex_valid,
    input  logic ex_mem,
    input  logic mem_done,
    output logic fetch_en,
    output logic stall,
    output logic capture
);
    phc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        fetch_en = 1'b1;
        stall    = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (ex_valid && ex_mem) begin
                    // MEM_ISSUE: hold fetch, delay the capture
                    fetch_en = 1'b0;
                    state_d  = ST_SUSPEND;
                end else begin
                    // FLOW
                    capture  = ex_valid;
                end
            end
            ST_SUSPEND: begin
                stall = 1'b1;
                if (mem_done) begin
                    // MEM_DONE
                    capture = 1'b1;
                    state_d = ST_RUN;
                end else begin
                    // MEM_WAIT
                    fetch_en = 1'b0;
                end
            end
            default: begin
                state_d  = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/phc_dest_latch.sv
`timescale 1ns/1ps
module phc_dest_latch #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              wen,
    input  logic [REG_AW-1:0] rd,
    input  logic [XLEN-1:0]   result,
    output logic              vld_q,
    output logic [REG_AW-1:0] rd_q,
    output logic [XLEN-1:0]   data_q
);
    logic writes_reg;
    assign writes_reg = wen && (rd != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            rd_q   <= '0;
            data_q <= '0;
        end else begin
            vld_q <= capture && writes_reg;
            if (capture) begin
                rd_q   <= rd;
                data_q <= result;
            end
        end
    end
endmodule

// File: rtl/phc_fwd_cmp.sv
`timescale 1ns/1ps
module phc_fwd_cmp #(
    parameter int unsigned NSRC   = 2,
    parameter int unsigned REG_AW = 5
) (
    input  logic                        enable,
    input  logic [NSRC-1:0][REG_AW-1:0] src,
    input  logic                        lat_vld,
    input  logic [REG_AW-1:0]           lat_rd,
    output logic [NSRC-1:0]             sel
);
    for (genvar i = 0; i < NSRC; i++) begin : g_port
        assign sel[i] = enable && lat_vld && (src[i] == lat_rd);
    end
endmodule

// File: rtl/pipe_hazard_ctl.sv
`timescale 1ns/1ps
module pipe_hazard_ctl #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_valid,
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_mem,
    input  logic              mem_done,
    input  logic [XLEN-1:0]   ex_result,
    output logic              fetch_en,
    output logic              fwd_rs1,
    output logic              fwd_rs2,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              stall
);
    localparam int unsigned NSRC = 2;

    logic                        capture;
    logic                        lat_vld;
    logic [REG_AW-1:0]           lat_rd;
    logic [XLEN-1:0]             lat_data;
    logic [NSRC-1:0][REG_AW-1:0] src_bus;
    logic [NSRC-1:0]             fwd_sel;

    phc_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ex_valid (ex_valid),
        .ex_mem   (ex_mem),
        .mem_done (mem_done),
        .fetch_en (fetch_en),
        .stall    (stall),
        .capture  (capture)
    );

    phc_dest_latch #(.XLEN(XLEN), .REG_AW(REG_AW)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .wen     (ex_wen),
        .rd      (ex_rd),
        .result  (ex_result),
        .vld_q   (lat_vld),
        .rd_q    (lat_rd),
        .data_q  (lat_data)
    );

    assign src_bus = {ex_rs2, ex_rs1};

    phc_fwd_cmp #(.NSRC(NSRC), .REG_AW(REG_AW)) u_fwd (
        .enable  (ex_valid),
        .src     (src_bus),
        .lat_vld (lat_vld),
        .lat_rd  (lat_rd),
        .sel     (fwd_sel)
    );

    assign fwd_rs1  = fwd_sel[0];
    assign fwd_rs2  = fwd_sel[1];
    assign rf_we    = lat_vld;
    assign rf_waddr = lat_rd;
    assign rf_wdata = lat_data;
endmodule

// File: rtl/phc_checker.sv
`timescale 1ns/1ps
module phc_checker #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_valid,
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_mem,
    input logic              mem_done,
    input logic [XLEN-1:0]   ex_result,
    input logic              fetch_en,
    input logic              fwd_rs1,
    input logic              rf_we,
    input logic [REG_AW-1:0] rf_waddr,
    input logic [XLEN-1:0]   rf_wdata,
    input logic              stall
);
    AST_COMMIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ex_valid && !ex_mem && ex_wen && ex_rd != '0)
        |=> (rf_we && rf_waddr == $past(ex_rd) && rf_wdata == $past(ex_result))); // R2
    AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != '0)); // R3
    AST_FWD_MATCHES_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_rs1 |-> (rf_we && ex_valid && rf_waddr == ex_rs1)); // R4
    AST_MEM_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ex_valid && ex_mem) |-> !fetch_en); // R7
    AST_MEM_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && ex_valid && ex_mem) |=> (stall && !rf_we)); // R7
    AST_ONE_CYCLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && mem_done) |=> !stall); // R8
    AST_WAIT_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !mem_done) |-> (!fetch_en ##1 stall)); // R9
    AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !ex_valid) |=> !rf_we); // R12
endmodule

bind pipe_hazard_ctl phc_checker #(.XLEN(XLEN), .REG_AW(REG_AW)) u_phc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_rs1    (ex_rs1),
    .ex_rd     (ex_rd),
    .ex_wen    (ex_wen),
    .ex_mem    (ex_mem),
    .mem_done  (mem_done),
    .ex_result (ex_result),
    .fetch_en  (fetch_en),
    .fwd_rs1   (fwd_rs1),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .rf_wdata  (rf_wdata),
    .stall     (stall)
);

// File: tb/pipe_hazard_ctl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_valid = 1'b0;
    logic [4:0]  ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic        ex_wen = 1'b0, ex_mem = 1'b0, mem_done = 1'b0;
    logic [31:0] ex_result = '0;
    logic        fetch_en, fwd_rs1, fwd_rs2, rf_we, stall;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    pipe_hazard_ctl uut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_rs1(ex_rs1),
        .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_mem(ex_mem),
        .mem_done(mem_done), .ex_result(ex_result), .fetch_en(fetch_en),
        .fwd_rs1(fwd_rs1), .fwd_rs2(fwd_rs2), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .stall(stall)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // present inputs just after a falling edge; outputs are checked 1 ns later
    task automatic put(input logic v, input logic [4:0] s1, input logic [4:0] s2,
                       input logic [4:0] d, input logic w, input logic m,
                       input logic dn, input logic [31:0] r);
        @(negedge clk);
        ex_valid = v; ex_rs1 = s1; ex_rs2 = s2; ex_rd = d;
        ex_wen = w; ex_mem = m; mem_done = dn; ex_result = r;
        #1;
    endtask

    task automatic bubble();
        put(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "rf_we in reset", rf_we, 0);
        chk("R1", "stall in reset", stall, 0);
        @(negedge clk);
        rst_n = 1'b1;
        bubble();
        chk("R1", "rf_we after reset", rf_we, 0);
        chk("R1", "fetch_en after reset", fetch_en, 1);
        chk("R1", "fwd_rs1 after reset", fwd_rs1, 0);
        chk("R1", "stall after reset", stall, 0);
    endtask

    task automatic t_back_to_back();
        bubble();
        put(1'b1, 5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 1'b0, 32'hA5A5_0001);
        chk("R6", "fwd_rs1 with empty latch", fwd_rs1, 0);
        put(1'b1, 5'd3, 5'd3, 5'd4, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        chk("R5", "fwd_rs1 both match", fwd_rs1, 1);
        chk("R5", "fwd_rs2 both match", fwd_rs2, 1);
        chk("R2", "commit we", rf_we, 1);
        chk("R2", "commit addr", rf_waddr, 5'd3);
        chk("R2", "commit data", rf_wdata, 32'hA5A5_0001);
        put(1'b1, 5'd4, 5'd3, 5'd0, 1'b1, 1'b0, 1'b0, 32'h1234_5678);
        chk("R4", "fwd_rs1 on rs1 match", fwd_rs1, 1);
        chk("R6", "fwd_rs2 two back", fwd_rs2, 0);
        chk("R2", "commit full-width data", rf_wdata, 32'hFFFF_FFFF);
        put(1'b1, 5'd0, 5'd0, 5'd31, 1'b1, 1'b0, 1'b0, 32'h8000_0000);
        chk("R3", "no write for rd 0", rf_we, 0);
        chk("R3", "no forward for rd 0", fwd_rs1, 0);
        put(1'b1, 5'd9, 5'd31, 5'd31, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R5", "fwd_rs2 alone", fwd_rs2, 1);
        chk("R5", "fwd_rs1 alone off", fwd_rs1, 0);
        chk("R2", "commit addr 31", rf_waddr, 5'd31);
        bubble();
        chk("R3", "no write for wen 0", rf_we, 0);
        chk("R2", "single-cycle commit", rf_we, 0);
    endtask

    task automatic t_load_use();
        bubble();
        put(1'b1, 5'd1, 5'd0, 5'd7, 1'b1, 1'b1, 1'b0, 32'h0);
        chk("R7", "fetch held on mem issue", fetch_en, 0);
        chk("R7", "no stall in issue cycle", stall, 0);
        put(1'b1, 5'd1, 5'd0, 5'd7, 1'b1, 1'b1, 1'b1, 32'hDEAD_BEEF);
        chk("R7", "stall next cycle", stall, 1);
        chk("R7", "no write while suspended", rf_we, 0);
        chk("R8", "fetch resumes on done", fetch_en, 1);
        put(1'b1, 5'd1, 5'd7, 5'd8, 1'b1, 1'b0, 1'b0, 32'h0000_0042);
        chk("R8", "stall lasts one cycle", stall, 0);
        chk("R10", "load commit we", rf_we, 1);
        chk("R10", "load commit addr", rf_waddr, 5'd7);
        chk("R10", "load commit data", rf_wdata, 32'hDEAD_BEEF);
        chk("R10", "load-use forward rs2", fwd_rs2, 1);
        chk("R10", "load-use rs1 no forward", fwd_rs1, 0);
        bubble();
        chk("R2", "after-load commit addr", rf_waddr, 5'd8);
        chk("R2", "after-load commit data", rf_wdata, 32'h0000_0042);
    endtask

    task automatic t_slow_mem();
        int stall_cycles = 0;
        bubble();
        put(1'b1, 5'd2, 5'd0, 5'd10, 1'b1, 1'b1, 1'b0, 32'h0);
        put(1'b1, 5'd2, 5'd0, 5'd10, 1'b1, 1'b1, 1'b0, 32'h0);
        if (stall) stall_cycles++;
        chk("R9", "fetch held while waiting", fetch_en, 0);
        put(1'b1, 5'd2, 5'd0, 5'd10, 1'b1, 1'b1, 1'b1, 32'h0BAD_F00D);
        if (stall) stall_cycles++;
        chk("R9", "still suspended", stall, 1);
        chk("R8", "fetch on done", fetch_en, 1);
        bubble();
        chk("R9", "stall count with one wait", stall_cycles, 2);
        chk("R10", "delayed load data", rf_wdata, 32'h0BAD_F00D);
        chk("R10", "delayed load we", rf_we, 1);
    endtask

    task automatic t_store();
        bubble();
        put(1'b1, 5'd5, 5'd0, 5'd6, 1'b0, 1'b1, 1'b0, 32'h0);
        chk("R7", "fetch held on store", fetch_en, 0);
        put(1'b1, 5'd5, 5'd0, 5'd6, 1'b0, 1'b1, 1'b1, 32'h1111_2222);
        chk("R11", "no write in store suspend", rf_we, 0);
        put(1'b1, 5'd6, 5'd6, 5'd1, 1'b1, 1'b0, 1'b0, 32'h0);
        chk("R11", "no write after store", rf_we, 0);
        chk("R11", "no forward from store", fwd_rs1, 0);
    endtask

    task automatic t_bubbles();
        bubble();
        put(1'b0, 5'd0, 5'd0, 5'd12, 1'b1, 1'b0, 1'b0, 32'h7777_7777);
        chk("R12", "bubble keeps fetch", fetch_en, 1);
        put(1'b1, 5'd12, 5'd12, 5'd13, 1'b1, 1'b0, 1'b0, 32'h1);
        chk("R12", "no write from bubble", rf_we, 0);
        chk("R12", "no forward from bubble", fwd_rs1, 0);
        put(1'b0, 5'd13, 5'd13, 5'd0, 1'b0, 1'b1, 1'b0, 32'h0);
        chk("R12", "invalid slot no forward", fwd_rs2, 0);
        chk("R12", "invalid mem no hold", fetch_en, 1);
        put(1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R12", "invalid mem no stall", stall, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done_flag) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_back_to_back();
        t_load_use();
        t_slow_mem();
        t_store();
        t_bubbles();
        t_reset();
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule